// File: doc/BRIEF.md
# Shared System Bus Ownership Agent

This block places one local bus master onto a system bus that several masters share. The local side raises a level request when it wants a system-bus cycle and pulses a completion flag when that cycle ends. The agent then competes for the shared bus. It raises a request line toward an external priority resolver and waits for that resolver to return priority. It also waits until the shared active-low busy line is free. Only then does it claim the bus, pulling the busy line low through an open-drain enable, and open the local command and driver path. While the path is closed, the local master sees no ready indication and stalls.

Once it owns the bus, the agent keeps it between transfers. It gives the bus up in three cases: it has lost priority, the local master has halted, or a strap input is set and some other agent is asking for the bus. In each case it waits until the transfer in progress has ended. All decisions are taken on the bus clock. There is no data stream through this block, so every pin is a plain control level without a valid/ready handshake.

Top module: `mma_agent`

## Requirements
- R1: After reset, the request output, the busy-pull enable and the driver enable are all low, and the agent is idle.
- R2: When idle, the request output goes high at the first clock edge that samples the local request high.
- R3: The driver enable is high only while the busy-pull enable is high. Both rise at the same edge and both fall at the same edge.
- R4: The agent takes the bus (busy-pull and driver enable go high) only at an edge where it has already been requesting, priority-in is high and the sensed busy line is high. Priority with the busy line held low by another agent does not take the bus.
- R5: An owner that loses priority during a transfer keeps the bus until the completion flag is sampled high. At that same edge it drops busy-pull and the driver enable.
- R6: After a transfer, if priority is still held, halt is low and no strapped yield applies, the owner stays parked on the bus. A new local request then proceeds with the driver enable staying high.
- R7: A parked owner that samples halt high releases the bus at that edge.
- R8: The other-request input has no effect while the strap is low. With the strap high, a parked owner that samples the other-request input high releases the bus at that edge.
- R9: The request output stays high during the release hold, which lasts REL_HOLD cycles (default 1). It then drops unless a local request is pending without halt. In that case it stays high and arbitration restarts.
- R10: A waiting agent that loses priority before the busy line frees returns to requesting and does not take the bus, even when the busy line goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every arbitration step happens on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_req | input | 1 | Local master wants a system-bus cycle (level, held until the cycle ends) |
| xfer_done | input | 1 | The current transfer completes this cycle |
| loc_halt | input | 1 | Local master is halted |
| yield_strap | input | 1 | Strap: also yield to requesters of lower priority |
| other_req | input | 1 | High while any other agent is requesting the bus |
| prio_in | input | 1 | Priority granted by the external resolver (active high) |
| busy_n_in | input | 1 | Sensed level of the shared active-low busy line |
| breq | output | 1 | Bus request toward the priority resolver |
| busy_drive | output | 1 | Open-drain enable; high pulls the shared busy line low |
| drv_en | output | 1 | Enables the local command generator and bus drivers |

## Verification
Acquisition is tried with priority arriving while another agent still holds the busy line, and with priority withdrawn while the agent waits. Together these separate a design that wrongly treats priority alone as a grant from one that correctly waits for the line to free. Release is tried four ways: lost priority in mid-transfer, halt, the other-request input with the strap low and then high, and a release with a fresh local request pending. These show whether the agent waits for completion, whether it ignores a lower-priority requester when it should, and whether the request line drops or stays high after the hold. A parked owner fed a new request shows that the driver enable never gaps between back-to-back transfers.

// File: rtl/mma_pkg.sv
`timescale 1ns/1ps
package mma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_WAIT    = 3'd2,
    ST_ACTIVE  = 3'd3,
    ST_PARKED  = 3'd4,
    ST_REL     = 3'd5
  } arb_state_t;
endpackage

// File: rtl/mma_yield.sv
`timescale 1ns/1ps
// Decides whether an owning agent must give up the bus at its next safe point.
module mma_yield (
  input  logic prio_in,
  input  logic loc_halt,
  input  logic yield_strap,
  input  logic other_req,
  output logic must_yield
);
  logic lower_wants;

  always_comb begin
    lower_wants = yield_strap & other_req;
    must_yield  = ~prio_in | loc_halt | lower_wants;
  end
endmodule

// File: rtl/mma_fsm.sv
`timescale 1ns/1ps
// Ownership sequencer: request, wait for free line, own, park, release.
module mma_fsm
  import mma_pkg::*;
#(
  parameter int REL_HOLD = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loc_req,
  input  logic       xfer_done,
  input  logic       loc_halt,
  input  logic       prio_in,
  input  logic       busy_n_in,
  input  logic       must_yield,
  output arb_state_t st
);
  localparam int CW = (REL_HOLD > 1) ? $clog2(REL_HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(REL_HOLD - 1);

  arb_state_t     st_nx;
  logic [CW-1:0]  rel_cnt;
  logic [CW-1:0]  rel_cnt_nx;

  always_comb begin
    st_nx      = st;
    rel_cnt_nx = '0;
    unique case (st)
      ST_IDLE:   if (loc_req) st_nx = ST_REQ;
      ST_REQ:    if (prio_in) st_nx = ST_WAIT;
      ST_WAIT: begin
        if (!prio_in)       st_nx = ST_REQ;
        else if (busy_n_in) st_nx = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (xfer_done) st_nx = must_yield ? ST_REL : ST_PARKED;
      end
      ST_PARKED: begin
        if (must_yield)   st_nx = ST_REL;
        else if (loc_req) st_nx = ST_ACTIVE;
      end
      ST_REL: begin
        if (rel_cnt == LAST) begin
          st_nx = (loc_req && !loc_halt) ? ST_REQ : ST_IDLE;
        end else begin
          rel_cnt_nx = rel_cnt + 1'b1;
        end
      end
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rel_cnt <= '0;
    end else begin
      st      <= st_nx;
      rel_cnt <= rel_cnt_nx;
    end
  end
endmodule

// File: rtl/mma_outs.sv
`timescale 1ns/1ps
// Decodes the registered state into the bus-side levels.
module mma_outs
  import mma_pkg::*;
(
  input  arb_state_t st,
  output logic       breq,
  output logic       busy_drive,
  output logic       drv_en
);
  logic owning;

  always_comb begin
    owning     = (st == ST_ACTIVE) || (st == ST_PARKED);
    breq       = (st != ST_IDLE);
    busy_drive = owning;
    drv_en     = owning;
  end
endmodule

// File: rtl/mma_agent.sv
`timescale 1ns/1ps
module mma_agent
  import mma_pkg::*;
#(
  parameter int REL_HOLD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_req,
  input  logic xfer_done,
  input  logic loc_halt,
  input  logic yield_strap,
  input  logic other_req,
  input  logic prio_in,
  input  logic busy_n_in,
  output logic breq,
  output logic busy_drive,
  output logic drv_en
);
  arb_state_t st;
  logic       must_yield;

  mma_yield u_yield (
    .prio_in    (prio_in),
    .loc_halt   (loc_halt),
    .yield_strap(yield_strap),
    .other_req  (other_req),
    .must_yield (must_yield)
  );

  mma_fsm #(.REL_HOLD(REL_HOLD)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_req   (loc_req),
    .xfer_done (xfer_done),
    .loc_halt  (loc_halt),
    .prio_in   (prio_in),
    .busy_n_in (busy_n_in),
    .must_yield(must_yield),
    .st        (st)
  );

  mma_outs u_outs (
    .st        (st),
    .breq      (breq),
    .busy_drive(busy_drive),
    .drv_en    (drv_en)
  );
endmodule

// File: rtl/mma_agent_chk.sv
`timescale 1ns/1ps
module mma_agent_chk
  import mma_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       loc_req,
  input logic       xfer_done,
  input logic       loc_halt,
  input logic       yield_strap,
  input logic       other_req,
  input logic       prio_in,
  input logic       busy_n_in,
  input logic       breq,
  input logic       busy_drive,
  input logic       drv_en,
  input arb_state_t st
);
  // R2
  breq_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!breq && loc_req) |=> breq);

  // R3
  drv_only_when_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> (busy_drive && breq));

  // R4
  take_needs_prio_and_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_drive) |-> ($past(prio_in) && $past(busy_n_in) && $past(breq)));

  // R5
  finish_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && !xfer_done) |=> busy_drive);

  // R6
  park_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PARKED && prio_in && !loc_halt && !(yield_strap && other_req))
      |=> (busy_drive && drv_en));

  // R7
  halt_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PARKED && loc_halt) |=> !busy_drive);
endmodule

bind mma_agent mma_agent_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .loc_req    (loc_req),
  .xfer_done  (xfer_done),
  .loc_halt   (loc_halt),
  .yield_strap(yield_strap),
  .other_req  (other_req),
  .prio_in    (prio_in),
  .busy_n_in  (busy_n_in),
  .breq       (breq),
  .busy_drive (busy_drive),
  .drv_en     (drv_en),
  .st         (st)
);

// File: tb/sim_mma_agent.sv
`timescale 1ns/1ps
module sim_mma_agent;
  logic clk = 1'b0;
  logic rst_n;
  logic loc_req, xfer_done, loc_halt, yield_strap, other_req, prio_in;
  logic ext_busy;
  logic busy_n_in;
  logic breq, busy_drive, drv_en;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  // wired busy line: low if this agent or any other pulls it
  assign busy_n_in = ~(busy_drive | ext_busy);

  mma_agent u0 (
    .clk(clk), .rst_n(rst_n), .loc_req(loc_req), .xfer_done(xfer_done),
    .loc_halt(loc_halt), .yield_strap(yield_strap), .other_req(other_req),
    .prio_in(prio_in), .busy_n_in(busy_n_in), .breq(breq),
    .busy_drive(busy_drive), .drv_en(drv_en)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; loc_req = 0; xfer_done = 0; loc_halt = 0;
    yield_strap = 0; other_req = 0; prio_in = 0; ext_busy = 0;
    step(); step();
    rst_n = 1'b1;
  endtask

  // request with priority and free line: REQ, WAIT, then owner on 3rd edge
  task automatic acquire();
    loc_req = 1; prio_in = 1; ext_busy = 0;
    step(); step(); step();
  endtask

  task automatic finish_xfer_keep();
    xfer_done = 1; loc_req = 0;
    step();
    xfer_done = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "breq after reset", breq, 1'b0);
    check("R1", "busy_drive after reset", busy_drive, 1'b0);
    check("R1", "drv_en after reset", drv_en, 1'b0);
  endtask

  task automatic t_wait_busy();
    do_reset();
    loc_req = 1; prio_in = 1; ext_busy = 1;
    step();
    check("R2", "breq first edge", breq, 1'b1);
    check("R3", "drv_en while requesting", drv_en, 1'b0);
    step();
    for (int i = 0; i < 3; i++) begin
      step();
      check("R4", "no take while line busy", busy_drive, 1'b0);
    end
    ext_busy = 0;
    step();
    check("R4", "take when line frees", busy_drive, 1'b1);
    check("R3", "drv_en rises with busy pull", drv_en, 1'b1);
  endtask

  task automatic t_lose_while_waiting();
    do_reset();
    loc_req = 1; prio_in = 1; ext_busy = 1;
    step(); step();
    prio_in = 0;
    step();
    ext_busy = 0;
    step(); step();
    check("R10", "no take after priority lost", busy_drive, 1'b0);
    check("R10", "still requesting", breq, 1'b1);
    prio_in = 1;
    step(); step();
    check("R10", "take once priority returns", busy_drive, 1'b1);
  endtask

  task automatic t_lose_mid_xfer();
    do_reset();
    acquire();
    prio_in = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R5", "hold during transfer", busy_drive, 1'b1);
    end
    xfer_done = 1; loc_req = 0;
    step();
    xfer_done = 0;
    check("R5", "release at completion", busy_drive, 1'b0);
    check("R3", "drv_en falls with busy pull", drv_en, 1'b0);
    check("R9", "breq held during release hold", breq, 1'b1);
    step();
    check("R9", "breq dropped after hold", breq, 1'b0);
  endtask

  task automatic t_park();
    do_reset();
    acquire();
    finish_xfer_keep();
    for (int i = 0; i < 4; i++) begin
      step();
      check("R6", "parked keeps bus", busy_drive, 1'b1);
    end
    loc_req = 1;
    step();
    check("R6", "next transfer without gap", drv_en, 1'b1);
    finish_xfer_keep();
    check("R6", "parked again", busy_drive, 1'b1);
  endtask

  task automatic t_strap();
    do_reset();
    acquire();
    finish_xfer_keep();
    other_req = 1;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R8", "other_req ignored without strap", busy_drive, 1'b1);
    end
    yield_strap = 1;
    step();
    check("R8", "yield with strap", busy_drive, 1'b0);
    other_req = 0; yield_strap = 0;
    step();
    check("R8", "idle after strap yield", breq, 1'b0);
  endtask

  task automatic t_halt();
    do_reset();
    acquire();
    finish_xfer_keep();
    loc_halt = 1;
    step();
    check("R7", "halt releases", busy_drive, 1'b0);
    step();
    check("R7", "halt leaves request low", breq, 1'b0);
    loc_halt = 0;
  endtask

  task automatic t_rerequest();
    do_reset();
    acquire();
    finish_xfer_keep();
    prio_in = 0; loc_req = 1;
    step();
    check("R9", "release before new request", busy_drive, 1'b0);
    check("R9", "breq during hold", breq, 1'b1);
    step();
    check("R9", "breq kept for pending request", breq, 1'b1);
    check("R9", "not owner while re-requesting", drv_en, 1'b0);
    step();
    check("R9", "breq still high", breq, 1'b1);
  endtask

  initial begin
    t_reset();
    t_wait_busy();
    t_lose_while_waiting();
    t_lose_mid_xfer();
    t_park();
    t_strap();
    t_halt();
    t_rerequest();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule